// File: doc/BRIEF.md
# GPIO bank register interface

This block is the register front end of a bank of general-purpose pins, 94 by default. A 32-bit read/write register bus reaches two kinds of storage. Bitmapped words hold one bit per pin, with pin p at bit p mod 32 of the p/32-th word of a group. Two configuration words per pin select between the pin's native function and plain GPIO use, set the direction and output level, gate the input buffer, choose a weak-pull option, and hold the trigger settings used by a separate interrupt detection block.

The block drives the pad output value, the output enable, the input-buffer enable and the pull-select code of every pin. It samples the pad inputs through a synchroniser. A firmware ownership map is captured from strap inputs while reset is held. A 0 in that map marks a pin as reserved for firmware, and the map cannot be changed over the bus. Software reads the map and leaves reserved pins alone.

Top module: `gpio_bank_regs`

## Requirements
- R1: While `rst_n` is low and immediately after it rises, every pin has mode select 0 (native), direction 1 (input) and sense-disable 1, with every other stored field 0. A read of configuration word 1 or word 2 of any pin then returns 0x00000004, and `pad_oe`, `pad_out`, `pad_ie` and `irq_en` are all zero.
- R2: The ownership map is three words at byte offsets 0x00, 0x04 and 0x08, with pin p at bit p mod 32 of word p/32. It returns the `strap_own` value captured while reset was low, and bus writes to it are ignored.
- R3: Configuration word 1 of pin p is at 0x100 + 8p. Its writable fields are bit 31 (output level), bit 4 (trigger select, 1 = level), bit 3 (trigger invert), bit 2 (direction, 1 = input) and bit 0 (mode, 1 = GPIO). All other bits except bit 30 read 0.
- R4: Configuration word 2 of pin p is at 0x104 + 8p. Bit 2 (sense-disable) and bits 1:0 (pull select) are writable and all other bits read 0. `pad_ie[p]` is the inverse of bit 2, and `pull_sel[2p+1:2p]` equals bits 1:0.
- R5: `pad_oe[p]` is 1 exactly when mode is 1 and direction is 0. `pad_out[p]` then equals the output-level bit and is 0 otherwise. Both change on the clock edge that completes the write.
- R6: Bit 30 of word 1 is read-only. It returns the pad input after `SYNC_STAGES` clock edges of synchronisation while sensing is enabled, and returns 0 while bit 2 of word 2 is set.
- R7: The interrupt-enable map is three read/write words at 0x90, 0x94 and 0x98, with pin p at bit p mod 32 of word p/32, driven on `irq_en`. Bits above the last pin read 0. `trig_level[p]` and `trig_inv[p]` follow bits 4 and 3 of word 1.
- R8: Read data appears on `bus_rdata` in the cycle after the edge that accepts the read, and is 0 in any cycle that follows a cycle without a read.
- R9: Every other offset reads 0 and ignores writes. This covers 0x0C to 0x8F (including the interrupt routing word at 0x7C and the status words from 0x80), 0x9C to 0xFF, and everything from 0x100 + 8·NUM_PINS upward.
- R10: A write to one pin's configuration leaves every other pin's configuration and pad signals unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; ownership straps are captured while low |
| strap_own | input | NUM_PINS | Ownership straps, 1 = available, 0 = reserved |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word-aligned byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_ie | output | NUM_PINS | Pad input-buffer enables |
| pull_sel | output | 2*NUM_PINS | Weak-pull selection, two bits per pin |
| trig_level | output | NUM_PINS | Trigger select per pin, to the interrupt block |
| trig_inv | output | NUM_PINS | Trigger invert per pin, to the interrupt block |
| irq_en | output | NUM_PINS | Interrupt enable per pin, to the interrupt block |

## Verification
A corrupted configuration record shows up at the pads on the edge right after the write that caused it. A wrong mode, direction or sense bit changes `pad_oe`, `pad_out` or `pad_ie` at once, and a bad pull field changes `pull_sel`, so pad checks follow each write directly. Faults in the readback path appear only on the next read, one cycle later. A fault in the input path appears `SYNC_STAGES` edges after the pad moves. Writes to unmapped and read-only locations are followed by reads and pad checks, so any stray state change becomes visible.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
   localparam int REG_W      = 32;
   // group base offsets (software visible)
   localparam int OFS_OWN    = 32'h000;
   localparam int OFS_IEN    = 32'h090;
   localparam int OFS_CFG    = 32'h100;
   localparam int CFG_STRIDE = 8;
   localparam int MAX_WORDS  = 28;
   // word 1 field positions
   localparam int C1_OUT  = 31;
   localparam int C1_IN   = 30;
   localparam int C1_TLVL = 4;
   localparam int C1_TINV = 3;
   localparam int C1_DIR  = 2;
   localparam int C1_MODE = 0;
   // word 2 field positions
   localparam int C2_NOSENSE = 2;
   localparam int C2_PULL_HI = 1;
   localparam int C2_PULL_LO = 0;

   typedef enum logic [1:0] {SP_NONE, SP_OWN, SP_IEN, SP_CFG} space_e;

   typedef struct packed {
      logic       out_lvl;
      logic       trig_lvl;
      logic       trig_inv;
      logic       dir_in;
      logic       gpio_mode;
      logic       sense_off;
      logic [1:0] pull;
   } pin_cfg_t;

   localparam pin_cfg_t CFG_RESET = '{out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0,
                                      dir_in: 1'b1, gpio_mode: 1'b0, sense_off: 1'b1,
                                      pull: 2'b00};
endpackage

// File: rtl/gpb_addr_dec.sv
module gpb_addr_dec
   import gpb_pkg::*;
#(
   parameter int NUM_PINS = 94,
   parameter int ADDR_W   = 12,
   localparam int NUM_WORDS = (NUM_PINS + REG_W - 1) / REG_W,
   localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
   localparam int PIN_W     = $clog2(NUM_PINS)
) (
   input  logic [ADDR_W-1:0] addr,
   output space_e            space,
   output logic [WIDX_W-1:0] word_idx,
   output logic [PIN_W-1:0]  pin_idx,
   output logic              hi_word
);
   localparam logic [ADDR_W-1:0] OWN_HI = ADDR_W'(OFS_OWN + 4 * NUM_WORDS);
   localparam logic [ADDR_W-1:0] IEN_LO = ADDR_W'(OFS_IEN);
   localparam logic [ADDR_W-1:0] IEN_HI = ADDR_W'(OFS_IEN + 4 * NUM_WORDS);
   localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(OFS_CFG + CFG_STRIDE * NUM_PINS);

   logic [ADDR_W-1:0] rel_ien;
   logic [ADDR_W-1:0] rel_cfg;
   logic              unused_low;

   assign rel_ien    = addr - IEN_LO;
   assign rel_cfg    = addr - CFG_LO;
   assign unused_low = ^{addr[1:0], rel_ien[1:0], rel_cfg[1:0]};

   // R9: anything outside the three windows decodes to SP_NONE
   always_comb begin
      space    = SP_NONE;
      word_idx = '0;
      pin_idx  = '0;
      hi_word  = 1'b0;
      if (addr >= CFG_LO && addr < CFG_HI) begin
         space   = SP_CFG;
         pin_idx = PIN_W'(rel_cfg >> 3);
         hi_word = rel_cfg[2];
      end else if (addr >= IEN_LO && addr < IEN_HI) begin
         space    = SP_IEN;
         word_idx = WIDX_W'(rel_ien >> 2);
      end else if (addr < OWN_HI) begin
         space    = SP_OWN;
         word_idx = WIDX_W'(addr >> 2);
      end
   end
endmodule

// File: rtl/gpb_in_sync.sv
module gpb_in_sync #(
   parameter int WIDTH  = 94,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign q = stage_q[STAGES-1];
   end
endmodule

// File: rtl/gpb_bitmaps.sv
module gpb_bitmaps
   import gpb_pkg::*;
#(
   parameter int NUM_PINS = 94,
   localparam int NUM_WORDS = (NUM_PINS + REG_W - 1) / REG_W,
   localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] strap_own,
   input  logic                ien_wr,
   input  logic [WIDX_W-1:0]   word_idx,
   input  logic [REG_W-1:0]    wdata,
   output logic [NUM_PINS-1:0] irq_en,
   output logic [REG_W-1:0]    own_word,
   output logic [REG_W-1:0]    ien_word
);
   logic [NUM_PINS-1:0]          own_q;
   logic [NUM_PINS-1:0]          ien_q;
   logic [NUM_WORDS*REG_W-1:0]   own_pad;
   logic [NUM_WORDS*REG_W-1:0]   ien_pad;

   // R2: straps are sampled on every edge while reset is held, then frozen
   always_ff @(posedge clk) begin
      if (!rst_n) own_q <= strap_own;
   end

   // R7: enable map, one bit per pin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0;
      end else if (ien_wr) begin
         for (int b = 0; b < NUM_PINS; b++) begin
            if (b / REG_W == int'(word_idx)) ien_q[b] <= wdata[b % REG_W];
         end
      end
   end

   assign irq_en = ien_q;

   always_comb begin
      own_pad = '0;
      ien_pad = '0;
      own_pad[NUM_PINS-1:0] = own_q;
      ien_pad[NUM_PINS-1:0] = ien_q;
      own_word = '0;
      ien_word = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (word_idx == WIDX_W'(w)) begin
            own_word = own_pad[w*REG_W +: REG_W];
            ien_word = ien_pad[w*REG_W +: REG_W];
         end
      end
   end
endmodule

// File: rtl/gpb_pin_bank.sv
module gpb_pin_bank
   import gpb_pkg::*;
#(
   parameter int NUM_PINS = 94,
   localparam int PIN_W = $clog2(NUM_PINS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic [PIN_W-1:0]      pin_idx,
   input  logic                  hi_word,
   input  logic [REG_W-1:0]      wdata,
   input  logic [NUM_PINS-1:0]   sync_in,
   output logic [REG_W-1:0]      cfg_word,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic [NUM_PINS-1:0]   pad_ie,
   output logic [2*NUM_PINS-1:0] pull_sel,
   output logic [NUM_PINS-1:0]   trig_level,
   output logic [NUM_PINS-1:0]   trig_inv
);
   pin_cfg_t            cfg_q [NUM_PINS];
   logic [NUM_PINS-1:0] sensed;
   pin_cfg_t            rd_cfg;
   logic                rd_sense;
   logic                unused_wdata;

   assign unused_wdata = ^wdata;

   // R1, R3, R4, R10: only the addressed pin's half-record is updated
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= CFG_RESET;
      end else if (cfg_wr) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_idx == PIN_W'(p)) begin
               if (hi_word) begin
                  cfg_q[p].sense_off <= wdata[C2_NOSENSE];
                  cfg_q[p].pull      <= wdata[C2_PULL_HI:C2_PULL_LO];
               end else begin
                  cfg_q[p].out_lvl   <= wdata[C1_OUT];
                  cfg_q[p].trig_lvl  <= wdata[C1_TLVL];
                  cfg_q[p].trig_inv  <= wdata[C1_TINV];
                  cfg_q[p].dir_in    <= wdata[C1_DIR];
                  cfg_q[p].gpio_mode <= wdata[C1_MODE];
               end
            end
         end
      end
   end

   // per-pin pad drive
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pad_oe[p]         = cfg_q[p].gpio_mode & ~cfg_q[p].dir_in;   // R5
      assign pad_out[p]        = pad_oe[p] & cfg_q[p].out_lvl;            // R5
      assign pad_ie[p]         = ~cfg_q[p].sense_off;                     // R4
      assign pull_sel[2*p +: 2] = cfg_q[p].pull;                          // R4
      assign trig_level[p]     = cfg_q[p].trig_lvl;                       // R7
      assign trig_inv[p]       = cfg_q[p].trig_inv;                       // R7
      assign sensed[p]         = sync_in[p] & ~cfg_q[p].sense_off;        // R6
   end

   // readback of the addressed record
   always_comb begin
      rd_cfg   = '0;
      rd_sense = 1'b0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (pin_idx == PIN_W'(p)) begin
            rd_cfg   = cfg_q[p];
            rd_sense = sensed[p];
         end
      end
      cfg_word = '0;
      if (hi_word) begin
         cfg_word[C2_NOSENSE]             = rd_cfg.sense_off;
         cfg_word[C2_PULL_HI:C2_PULL_LO]  = rd_cfg.pull;
      end else begin
         cfg_word[C1_OUT]  = rd_cfg.out_lvl;
         cfg_word[C1_IN]   = rd_sense;
         cfg_word[C1_TLVL] = rd_cfg.trig_lvl;
         cfg_word[C1_TINV] = rd_cfg.trig_inv;
         cfg_word[C1_DIR]  = rd_cfg.dir_in;
         cfg_word[C1_MODE] = rd_cfg.gpio_mode;
      end
   end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpb_pkg::*;
#(
   parameter int NUM_PINS    = 94,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   strap_own,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [REG_W-1:0]      bus_wdata,
   output logic [REG_W-1:0]      bus_rdata,
   input  logic [NUM_PINS-1:0]   pad_in,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic [NUM_PINS-1:0]   pad_ie,
   output logic [2*NUM_PINS-1:0] pull_sel,
   output logic [NUM_PINS-1:0]   trig_level,
   output logic [NUM_PINS-1:0]   trig_inv,
   output logic [NUM_PINS-1:0]   irq_en
);
   localparam int NUM_WORDS = (NUM_PINS + REG_W - 1) / REG_W;
   localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int PIN_W     = $clog2(NUM_PINS);
   localparam longint CFG_END = longint'(OFS_CFG) + longint'(CFG_STRIDE) * NUM_PINS;

   // elaboration-time parameter checks
   if (NUM_PINS < 2) begin : g_bad_pins
      $error("gpio_bank_regs: NUM_PINS must be at least 2");
   end
   if (NUM_WORDS > MAX_WORDS) begin : g_bad_words
      $error("gpio_bank_regs: bitmap groups would overlap");
   end
   if (CFG_END > (longint'(1) << ADDR_W)) begin : g_bad_addr
      $error("gpio_bank_regs: ADDR_W too small for the configuration area");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("gpio_bank_regs: SYNC_STAGES must not be negative");
   end

   space_e            space;
   logic [WIDX_W-1:0] word_idx;
   logic [PIN_W-1:0]  pin_idx;
   logic              hi_word;
   logic              rd_req;
   logic              wr_req;
   logic [NUM_PINS-1:0] sync_in;
   logic [REG_W-1:0]  own_word;
   logic [REG_W-1:0]  ien_word;
   logic [REG_W-1:0]  cfg_word;
   logic [REG_W-1:0]  rd_mux;
   logic [REG_W-1:0]  rdata_q;

   assign rd_req = bus_sel & ~bus_wr;
   assign wr_req = bus_sel &  bus_wr;

   gpb_addr_dec #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
      .addr     (bus_addr),
      .space    (space),
      .word_idx (word_idx),
      .pin_idx  (pin_idx),
      .hi_word  (hi_word)
   );

   gpb_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_in)
   );

   gpb_bitmaps #(.NUM_PINS(NUM_PINS)) u_maps (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_own (strap_own),
      .ien_wr    (wr_req && space == SP_IEN),
      .word_idx  (word_idx),
      .wdata     (bus_wdata),
      .irq_en    (irq_en),
      .own_word  (own_word),
      .ien_word  (ien_word)
   );

   gpb_pin_bank #(.NUM_PINS(NUM_PINS)) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (wr_req && space == SP_CFG),
      .pin_idx    (pin_idx),
      .hi_word    (hi_word),
      .wdata      (bus_wdata),
      .sync_in    (sync_in),
      .cfg_word   (cfg_word),
      .pad_out    (pad_out),
      .pad_oe     (pad_oe),
      .pad_ie     (pad_ie),
      .pull_sel   (pull_sel),
      .trig_level (trig_level),
      .trig_inv   (trig_inv)
   );

   // R9: unmapped space contributes zero
   always_comb begin
      case (space)
         SP_OWN:  rd_mux = own_word;
         SP_IEN:  rd_mux = ien_word;
         SP_CFG:  rd_mux = cfg_word;
         default: rd_mux = '0;
      endcase
   end

   // R8: registered readout, zero when no read was accepted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_req) rdata_q <= rd_mux;
      else             rdata_q <= '0;
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
   import gpb_pkg::*;
#(
   parameter int NUM_PINS = 94,
   parameter int ADDR_W   = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [REG_W-1:0]    bus_wdata,
   input logic [REG_W-1:0]    bus_rdata,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_ie
);
   localparam logic [ADDR_W-1:0] A_W1_P0  = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_W2_P0  = ADDR_W'(OFS_CFG + 4);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(32'h080);

   logic wr_w1_p0;
   logic wr_w2_p0;
   logic rd_any;

   assign wr_w1_p0 = bus_sel && bus_wr && bus_addr == A_W1_P0;
   assign wr_w2_p0 = bus_sel && bus_wr && bus_addr == A_W2_P0;
   assign rd_any   = bus_sel && !bus_wr;

   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && pad_ie == '0));

   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_any |=> bus_rdata == '0);

   a_r9_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && bus_addr == A_STATUS) |=> bus_rdata == '0);

   a_r5_native_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_w1_p0 && !bus_wdata[C1_MODE]) |=> !pad_oe[0]);

   a_r5_output_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_w1_p0 && bus_wdata[C1_MODE] && !bus_wdata[C1_DIR]) |=> pad_oe[0]);

   a_r4_sense_off: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_w2_p0 && bus_wdata[C2_NOSENSE]) |=> !pad_ie[0]);

   a_r4_sense_on: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_w2_p0 && !bus_wdata[C2_NOSENSE]) |=> pad_ie[0]);

   a_r6_masked_input: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && bus_addr == A_W1_P0 && !pad_ie[0]) |=> !bus_rdata[C1_IN]);
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_oe    (pad_oe),
   .pad_ie    (pad_ie)
);

// File: tb/gpio_bank_regs_tb_top.sv
module gpio_bank_regs_tb_top;
   localparam int NP = 94;
   localparam int AW = 12;
   localparam int NV = 29;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NP-1:0]   strap_own;
   logic            bus_sel;
   logic            bus_wr;
   logic [AW-1:0]   bus_addr;
   logic [31:0]     bus_wdata;
   logic [31:0]     bus_rdata;
   logic [NP-1:0]   pad_in;
   logic [NP-1:0]   pad_out;
   logic [NP-1:0]   pad_oe;
   logic [NP-1:0]   pad_ie;
   logic [2*NP-1:0] pull_sel;
   logic [NP-1:0]   trig_level;
   logic [NP-1:0]   trig_inv;
   logic [NP-1:0]   irq_en;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;   // 50 MHz

   gpio_bank_regs #(.NUM_PINS(NP), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .strap_own(strap_own),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
      .pull_sel(pull_sel), .trig_level(trig_level), .trig_inv(trig_inv),
      .irq_en(irq_en)
   );

   // {write, address, write data, expected read data}
   localparam logic [76:0] VEC [NV] = '{
      {1'b0, 12'h000, 32'h0, 32'hA5A50F0F},
      {1'b0, 12'h004, 32'h0, 32'h12345678},
      {1'b0, 12'h008, 32'h0, 32'h2BADBEEF},
      {1'b1, 12'h000, 32'hFFFFFFFF, 32'h0},
      {1'b0, 12'h000, 32'h0, 32'hA5A50F0F},
      {1'b0, 12'h100, 32'h0, 32'h00000004},
      {1'b0, 12'h104, 32'h0, 32'h00000004},
      {1'b0, 12'h108, 32'h0, 32'h00000004},
      {1'b1, 12'h100, 32'hFFFFFFFF, 32'h0},
      {1'b0, 12'h100, 32'h0, 32'h8000001D},
      {1'b1, 12'h104, 32'hFFFFFFFF, 32'h0},
      {1'b0, 12'h104, 32'h0, 32'h00000007},
      {1'b1, 12'h104, 32'h00000003, 32'h0},
      {1'b0, 12'h104, 32'h0, 32'h00000003},
      {1'b1, 12'h3E8, 32'h80000001, 32'h0},
      {1'b0, 12'h3E8, 32'h0, 32'h80000001},
      {1'b0, 12'h3EC, 32'h0, 32'h00000004},
      {1'b1, 12'h3F0, 32'hFFFFFFFF, 32'h0},
      {1'b0, 12'h3F0, 32'h0, 32'h00000000},
      {1'b1, 12'h090, 32'hFFFFFFFF, 32'h0},
      {1'b1, 12'h098, 32'hFFFFFFFF, 32'h0},
      {1'b0, 12'h090, 32'h0, 32'hFFFFFFFF},
      {1'b0, 12'h094, 32'h0, 32'h00000000},
      {1'b0, 12'h098, 32'h0, 32'h3FFFFFFF},
      {1'b1, 12'h080, 32'hFFFFFFFF, 32'h0},
      {1'b0, 12'h080, 32'h0, 32'h00000000},
      {1'b0, 12'h07C, 32'h0, 32'h00000000},
      {1'b0, 12'h00C, 32'h0, 32'h00000000},
      {1'b0, 12'h108, 32'h0, 32'h00000004}
   };

   function automatic string vec_req(int i);
      if (i <= 4)  return "R2";
      if (i <= 7)  return "R1";
      if (i <= 9)  return "R3";
      if (i <= 13) return "R4";
      if (i <= 16) return "R3";
      if (i <= 18) return "R9";
      if (i <= 23) return "R7";
      if (i <= 27) return "R9";
      return "R10";
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [NP-1:0] exp_ien;
      rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      pad_in = '0;
      strap_own = {30'h2BADBEEF, 32'h12345678, 32'hA5A50F0F};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state at the ports, R8 idle read data
      chk("R1 pad_oe", 128'(pad_oe), 128'(0));
      chk("R1 pad_out", 128'(pad_out), 128'(0));
      chk("R1 pad_ie", 128'(pad_ie), 128'(0));
      chk("R1 irq_en", 128'(irq_en), 128'(0));
      chk("R8 rdata idle", 128'(bus_rdata), 128'(0));

      // vector table
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][76]) begin
            bus_write(VEC[i][75:64], VEC[i][63:32]);
         end else begin
            bus_read(VEC[i][75:64], rd);
            chk(vec_req(i), 128'(rd), 128'(VEC[i][31:0]));
         end
      end

      // R5 drive after table: pin 93 GPIO output high, pin 0 GPIO input
      chk("R5 oe93", 128'(pad_oe[93]), 128'(1));
      chk("R5 out93", 128'(pad_out[93]), 128'(1));
      chk("R5 oe0 input", 128'(pad_oe[0]), 128'(0));
      chk("R5 out0 input", 128'(pad_out[0]), 128'(0));

      // R4 pull and input enable of pin 0 (word 2 = 3)
      chk("R4 pull0", 128'(pull_sel[1:0]), 128'(3));
      chk("R4 ie0", 128'(pad_ie[0]), 128'(1));
      chk("R4 ie1 untouched", 128'(pad_ie[1]), 128'(0));

      // R7 trigger bits and enable map
      chk("R7 trig_level0", 128'(trig_level[0]), 128'(1));
      chk("R7 trig_inv0", 128'(trig_inv[0]), 128'(1));
      exp_ien = '0;
      for (int b = 0; b < 32; b++) exp_ien[b] = 1'b1;
      for (int b = 64; b < NP; b++) exp_ien[b] = 1'b1;
      chk("R7 irq_en", 128'(irq_en), 128'(exp_ien));

      // R5 mode/direction combinations on pin 0
      bus_write(12'h100, 32'h80000001);
      chk("R5 gpio out high oe", 128'(pad_oe[0]), 128'(1));
      chk("R5 gpio out high val", 128'(pad_out[0]), 128'(1));
      bus_write(12'h100, 32'h00000001);
      chk("R5 gpio out low oe", 128'(pad_oe[0]), 128'(1));
      chk("R5 gpio out low val", 128'(pad_out[0]), 128'(0));
      bus_write(12'h100, 32'h80000000);
      chk("R5 native oe", 128'(pad_oe[0]), 128'(0));
      chk("R5 native val", 128'(pad_out[0]), 128'(0));

      // R6 sampled input with sensing on (word 2 = 3)
      pad_in[0] = 1'b1;
      repeat (3) @(negedge clk);
      bus_read(12'h100, rd);
      chk("R6 input high sensed", 128'(rd), 128'(32'hC0000000));
      bus_write(12'h104, 32'h00000004);
      bus_read(12'h100, rd);
      chk("R6 input masked", 128'(rd), 128'(32'h80000000));
      chk("R4 ie0 off", 128'(pad_ie[0]), 128'(0));
      // R6 bit 30 not writable
      bus_write(12'h104, 32'h00000000);
      pad_in[0] = 1'b0;
      bus_write(12'h100, 32'h40000000);
      repeat (3) @(negedge clk);
      bus_read(12'h100, rd);
      chk("R6 bit30 write ignored", 128'(rd), 128'(0));

      // R10 other pins unaffected
      chk("R10 pad_oe only pin93", 128'(pad_oe), 128'({1'b1, 93'b0}));
      bus_read(12'h3E8, rd);
      chk("R10 pin93 record", 128'(rd), 128'(32'h80000001));

      // R8 read data returns to zero after an idle cycle
      bus_read(12'h000, rd);
      chk("R8 read data", 128'(rd), 128'(32'hA5A50F0F));
      @(negedge clk);
      chk("R8 zero after idle", 128'(bus_rdata), 128'(0));

      summary();
      $finish;
   end
endmodule